// File: doc/BRIEF.md
# Oversize Copy Splitter and Sequencer

This block takes memory-to-memory copy requests whose length may be any value up to the full length width and feeds them to a copy engine that can move only a bounded number of bytes per transfer. Requests enter through a small first-in first-out buffer with a valid/ready handshake. Each request carries a tag, a source address, a destination address and a byte length. The sequencer cuts the request into consecutive pieces. Each piece holds the engine maximum of 2^CHUNK_W−1 bytes, except the final piece, which holds what is left. The pieces go to the engine one at a time through a start/done handshake.

The block keeps a running residue for the request in flight. It lowers the residue as each piece finishes and signals completion of the whole request, with its tag, only once the residue reaches zero. A status port returns the residue of a tag. Before every launch the sequencer waits for the engine to report idle. If that wait exceeds a programmable cycle count, a sticky error flag is raised.

Top module: `chunk_copy_seq`

## Requirements
- R1: A request of length L > 0 produces exactly ceil(L / (2^CHUNK_W−1)) launches. Every launch but the final one has length 2^CHUNK_W−1, and the final one has the remainder, so no launch length is 0 or above the maximum.
- R2: The first launch of a request uses the request's source and destination. Each later launch uses addresses advanced, modulo 2^ADDR_W, by the length of the launch before it.
- R3: While a request is in flight its residue equals its length minus the lengths of the launches whose eng_done has been taken. The residue drops by one launch length on the clock edge that samples that launch's eng_done.
- R4: done_valid pulses for one cycle, with done_tag set to the request tag, on the clock edge that samples eng_done for the request's final launch. It never pulses earlier.
- R5: Requests are served strictly in arrival order. req_ready is low exactly while the buffer holds DEPTH requests.
- R6: At most one launch is outstanding. eng_start is a one-cycle pulse issued on the edge after the sequencer, waiting for a launch, samples eng_idle high.
- R7: With timeout_limit = N > 0, err_timeout rises when the sequencer has sampled eng_idle low on N consecutive edges while waiting to launch. It then stays high until reset. N = 0 disables the check.
- R8: query_residue returns the residue when query_tag matches the request in flight, and 0 for any other tag or when nothing is in flight.
- R9: A request of length 0 pulses done_valid with its tag on the edge that removes it from the buffer, and issues no eng_start.
- R10: After reset, eng_start, done_valid and err_timeout are low, req_ready is high and query_residue is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Buffer has room |
| req_tag | input | TAG_W | Request tag |
| req_src | input | ADDR_W | Request source address |
| req_dst | input | ADDR_W | Request destination address |
| req_len | input | LEN_W | Request length in bytes |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_src | output | ADDR_W | Launch source address |
| eng_dst | output | ADDR_W | Launch destination address |
| eng_len | output | CHUNK_W | Launch length |
| eng_done | input | 1 | Engine finished the outstanding launch |
| eng_idle | input | 1 | Engine ready for a launch |
| timeout_limit | input | TMO_W | Idle wait limit in cycles, 0 disables |
| err_timeout | output | 1 | Sticky idle-wait timeout flag |
| done_valid | output | 1 | Request completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |
| query_tag | input | TAG_W | Tag for the residue query |
| query_residue | output | LEN_W | Residue of the queried tag, or 0 |

## Verification
A launch is due on the edge after the sequencer sees the engine idle, and it is registered, so the bench samples eng_start and its fields on the falling edge that follows. The residue and done_valid both change on the edge that takes eng_done, which the bench drives at a falling edge. It therefore looks for the completion one falling edge later and reads the residue in between. A zero-length request completes two edges after it is accepted. The residue query is combinational on registered state, so the bench sets query_tag and reads the answer within the same low phase of the clock. The timeout flag is checked only after several edges, well past the programmed limit, or well before it is reached.

// File: rtl/ccs_pkg.sv
// Shared types for the chunked copy sequencer.
package ccs_pkg;
    // Sequencer phases: no parent, waiting for engine idle, chunk running.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_BUSY = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ccs_req_fifo.sv
// Request buffer: a plain first-in first-out store of flattened requests.
// Assumes the consumer pops only when not empty and the producer pushes
// only when not full.
module ccs_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign dout      = mem[rd_ptr];

    // Store pushed entries.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/ccs_chunk_size.sv
// Chunk length: the smaller of the remaining bytes and the engine maximum
// 2^CHUNK_W-1. Assumes LEN_W > CHUNK_W.
module ccs_chunk_size #(
    parameter int LEN_W   = 64,
    parameter int CHUNK_W = 28
) (
    input  logic [LEN_W-1:0]   remaining,
    output logic [CHUNK_W-1:0] chunk
);
    localparam logic [LEN_W-1:0] MAX_LEN = {{(LEN_W - CHUNK_W){1'b0}}, {CHUNK_W{1'b1}}};

    // Clamp to the engine limit.
    always_comb begin
        if (remaining > MAX_LEN) chunk = {CHUNK_W{1'b1}};
        else                     chunk = remaining[CHUNK_W-1:0];
    end
endmodule

// File: rtl/ccs_idle_watch.sv
// Idle-wait watchdog: counts consecutive cycles spent waiting with the
// engine busy and raises a sticky flag when the count reaches the limit.
// A limit of zero disables the flag.
module ccs_idle_watch #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic             idle,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    // Count busy cycles while waiting and latch the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (waiting && !idle) begin
            if (!cnt_inc[TMO_W]) cnt <= cnt_inc[TMO_W-1:0];
            if ((limit != '0) && (cnt_inc >= {1'b0, limit})) expired <= 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/chunk_copy_seq.sv
// Oversize copy splitter and sequencer. Pops one request at a time, issues
// its chunks to the engine in order, tracks the residue and reports the
// request complete when the residue reaches zero. Assumes the engine pulses
// eng_done once per eng_start and that ADDR_W and LEN_W exceed CHUNK_W.
module chunk_copy_seq
    import ccs_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int ADDR_W  = 64,
    parameter int LEN_W   = 64,
    parameter int CHUNK_W = 28,
    parameter int DEPTH   = 4,
    parameter int TMO_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [ADDR_W-1:0]  req_src,
    input  logic [ADDR_W-1:0]  req_dst,
    input  logic [LEN_W-1:0]   req_len,
    output logic               eng_start,
    output logic [ADDR_W-1:0]  eng_src,
    output logic [ADDR_W-1:0]  eng_dst,
    output logic [CHUNK_W-1:0] eng_len,
    input  logic               eng_done,
    input  logic               eng_idle,
    input  logic [TMO_W-1:0]   timeout_limit,
    output logic               err_timeout,
    output logic               done_valid,
    output logic [TAG_W-1:0]   done_tag,
    input  logic [TAG_W-1:0]   query_tag,
    output logic [LEN_W-1:0]   query_residue
);
    localparam int REQ_W = TAG_W + 2 * ADDR_W + LEN_W;

    seq_state_e         state;
    logic               fifo_full, fifo_nonempty, fifo_pop;
    logic [REQ_W-1:0]   fifo_dout;
    logic [TAG_W-1:0]   head_tag, cur_tag;
    logic [ADDR_W-1:0]  head_src, head_dst, cur_src, cur_dst, chunk_addr;
    logic [LEN_W-1:0]   head_len, residue, chunk_ext;
    logic [CHUNK_W-1:0] chunk_len;

    assign req_ready = !fifo_full;
    assign fifo_pop  = (state == SEQ_IDLE) && fifo_nonempty;
    assign {head_tag, head_src, head_dst, head_len} = fifo_dout;

    ccs_req_fifo #(.W(REQ_W), .DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid && !fifo_full),
        .din       ({req_tag, req_src, req_dst, req_len}),
        .full      (fifo_full),
        .pop       (fifo_pop),
        .dout      (fifo_dout),
        .not_empty (fifo_nonempty)
    );

    ccs_chunk_size #(.LEN_W(LEN_W), .CHUNK_W(CHUNK_W)) i_chunk (
        .remaining (residue),
        .chunk     (chunk_len)
    );

    ccs_idle_watch #(.TMO_W(TMO_W)) i_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (state == SEQ_WAIT),
        .idle    (eng_idle),
        .limit   (timeout_limit),
        .expired (err_timeout)
    );

    assign chunk_ext  = {{(LEN_W - CHUNK_W){1'b0}}, chunk_len};
    assign chunk_addr = {{(ADDR_W - CHUNK_W){1'b0}}, chunk_len};

    // Residue lookup for the single parent in flight.
    assign query_residue = ((state != SEQ_IDLE) && (query_tag == cur_tag)) ? residue : '0;

    // Sequencer: load parent, launch chunks on idle, account completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            eng_start  <= 1'b0;
            done_valid <= 1'b0;
            done_tag   <= '0;
            eng_src    <= '0;
            eng_dst    <= '0;
            eng_len    <= '0;
            cur_tag    <= '0;
            cur_src    <= '0;
            cur_dst    <= '0;
            residue    <= '0;
        end else begin
            eng_start  <= 1'b0;
            done_valid <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (fifo_nonempty) begin
                        cur_tag <= head_tag;
                        cur_src <= head_src;
                        cur_dst <= head_dst;
                        residue <= head_len;
                        if (head_len == '0) begin
                            done_valid <= 1'b1;
                            done_tag   <= head_tag;
                        end else begin
                            state <= SEQ_WAIT;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (eng_idle) begin
                        eng_start <= 1'b1;
                        eng_src   <= cur_src;
                        eng_dst   <= cur_dst;
                        eng_len   <= chunk_len;
                        state     <= SEQ_BUSY;
                    end
                end
                SEQ_BUSY: begin
                    if (eng_done) begin
                        residue <= residue - chunk_ext;
                        cur_src <= cur_src + chunk_addr;
                        cur_dst <= cur_dst + chunk_addr;
                        if (residue == chunk_ext) begin
                            done_valid <= 1'b1;
                            done_tag   <= cur_tag;
                            state      <= SEQ_IDLE;
                        end else begin
                            state <= SEQ_WAIT;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ccs_checker.sv
// Protocol checker for chunk_copy_seq, bound to every instance. Tracks the
// outstanding launch from the engine handshake alone.
module ccs_checker #(
    parameter int CHUNK_W = 28
) (
    input logic               clk,
    input logic               rst_n,
    input logic               eng_start,
    input logic [CHUNK_W-1:0] eng_len,
    input logic               eng_done,
    input logic               eng_idle,
    input logic               err_timeout,
    input logic               done_valid
);
    logic outst;

    // Outstanding launch: set by start, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)         outst <= 1'b0;
        else if (eng_start) outst <= 1'b1;
        else if (eng_done)  outst <= 1'b0;
    end

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !outst);

    assert_start_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(eng_idle));

    assert_chunk_len_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_len != '0));

    assert_no_done_while_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !outst);

    assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
endmodule

bind chunk_copy_seq ccs_checker #(.CHUNK_W(CHUNK_W)) i_ccs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_start   (eng_start),
    .eng_len     (eng_len),
    .eng_done    (eng_done),
    .eng_idle    (eng_idle),
    .err_timeout (err_timeout),
    .done_valid  (done_valid)
);

// File: tb/test_chunk_copy_seq.sv
`timescale 1ns/100ps
module test_chunk_copy_seq;
    localparam int TAG_W = 8, ADDR_W = 64, LEN_W = 64, CHUNK_W = 3, DEPTH = 4, TMO_W = 8;
    localparam logic [63:0] MAXC = 64'd7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [TAG_W-1:0] req_tag = '0, done_tag, query_tag = '0;
    logic [ADDR_W-1:0] req_src = '0, req_dst = '0, eng_src, eng_dst;
    logic [LEN_W-1:0] req_len = '0, query_residue;
    logic eng_start, eng_done = 1'b0, eng_idle, err_timeout, done_valid;
    logic [CHUNK_W-1:0] eng_len;
    logic [TMO_W-1:0] timeout_limit = 8'd4;
    logic eng_busy = 1'b0, force_busy = 1'b0;

    assign eng_idle = !eng_busy && !force_busy;
    always #2.5 clk = !clk;

    chunk_copy_seq #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_W(CHUNK_W),
                     .DEPTH(DEPTH), .TMO_W(TMO_W)) i_chunk_copy_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_tag(req_tag), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .eng_start(eng_start), .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
        .eng_done(eng_done), .eng_idle(eng_idle), .timeout_limit(timeout_limit),
        .err_timeout(err_timeout), .done_valid(done_valid), .done_tag(done_tag),
        .query_tag(query_tag), .query_residue(query_residue));

    int n_cmp = 0, n_bad = 0;
    logic [63:0] q_src [64], q_dst [64], q_len [64];
    logic [7:0]  q_tag [64];
    int wi = 0, ci = 0, nch = 0, lat = 1, lat_cnt = 0;
    logic [63:0] off = 0;
    bit outst = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] t, input logic [63:0] s, input logic [63:0] d,
                        input logic [63:0] l);
        q_tag[wi] = t; q_src[wi] = s; q_dst[wi] = d; q_len[wi] = l; wi++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_tag = t; req_src = s; req_dst = d; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (ci != wi && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(ci == wi, "R5", "all requests completed", 64'(ci), 64'(wi));
    endtask

    // Engine model and output monitor, all on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (eng_done) eng_done = 1'b0;
                if (lat_cnt > 0) begin
                    lat_cnt--;
                    if (lat_cnt == 0) begin
                        eng_done = 1'b1; eng_busy = 1'b0; outst = 0;
                    end
                end
                if (eng_start) begin
                    logic [63:0] rem, exp_len;
                    rem = q_len[ci] - off;
                    exp_len = (rem > MAXC) ? MAXC : rem;
                    chk(!outst, "R6", "launch while outstanding", 64'(outst), 64'd0);
                    chk(64'(eng_len) == exp_len, "R1", "chunk length", 64'(eng_len), exp_len);
                    chk(eng_src == q_src[ci] + off, "R2", "chunk source", eng_src, q_src[ci] + off);
                    chk(eng_dst == q_dst[ci] + off, "R2", "chunk destination", eng_dst, q_dst[ci] + off);
                    query_tag = q_tag[ci];
                    #0.5;
                    chk(query_residue == rem, "R3", "residue before chunk done", query_residue, rem);
                    query_tag = q_tag[ci] ^ 8'h80;
                    #0.5;
                    chk(query_residue == 0, "R8", "residue of other tag", query_residue, 64'd0);
                    off = off + exp_len; nch++;
                    eng_busy = 1'b1; outst = 1; lat_cnt = lat;
                end
                if (done_valid) begin
                    int exp_n;
                    exp_n = int'((q_len[ci] + MAXC - 1) / MAXC);
                    chk(done_tag == q_tag[ci], "R5", "completion order tag", 64'(done_tag), 64'(q_tag[ci]));
                    chk(off == q_len[ci] && !outst, "R4", "completion after last chunk", off, q_len[ci]);
                    if (q_len[ci] == 0)
                        chk(nch == 0, "R9", "zero length launches", 64'(nch), 64'd0);
                    else
                        chk(nch == exp_n, "R1", "chunk count", 64'(nch), 64'(exp_n));
                    query_tag = q_tag[ci];
                    #0.5;
                    chk(query_residue == 0, "R8", "residue after completion", query_residue, 64'd0);
                    ci++; off = 0; nch = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!eng_start && !done_valid, "R10", "start/done after reset", {eng_start, done_valid}, 0);
        chk(!err_timeout, "R10", "timeout flag after reset", 64'(err_timeout), 0);
        chk(req_ready, "R10", "ready after reset", 64'(req_ready), 1);
        chk(query_residue == 0, "R10", "residue after reset", query_residue, 0);

        // Sweep lengths 0..30, one request at a time, with address wrap.
        for (int l = 0; l <= 30; l++) begin
            lat = l % 3 + 1;
            push(8'(l), 64'h1000_0000_0000_0000 + 64'(l) * 256, 64'hFFFF_FFFF_FFFF_FFF0 - 64'(l), 64'(l));
            drain();
        end

        // Back-to-back burst, mixed lengths including zero.
        lat = 2;
        for (int k = 0; k < 8; k++)
            push(8'(40 + k), 64'(k) * 64'h100, 64'h8000 + 64'(k), 64'((k * 5) % 17));
        drain();

        // R7: short busy wait below the limit does not flag.
        force_busy = 1'b1;
        push(8'd60, 64'h200, 64'h300, 64'd3);
        @(negedge clk);
        @(negedge clk);
        force_busy = 1'b0;
        drain();
        chk(!err_timeout, "R7", "no timeout below limit", 64'(err_timeout), 0);

        // R7 and R5: long busy wait flags; buffer fills while stuck.
        force_busy = 1'b1;
        for (int k = 0; k < 5; k++)
            push(8'(70 + k), 64'h1000 * 64'(k + 1), 64'h9000 + 64'(k), 64'(k + 9));
        chk(!req_ready, "R5", "ready low with buffer full", 64'(req_ready), 0);
        repeat (4) @(negedge clk);
        chk(err_timeout, "R7", "timeout after limit", 64'(err_timeout), 1);
        chk(nch == 0, "R6", "no launch while engine busy", 64'(nch), 0);
        force_busy = 1'b0;
        drain();
        chk(err_timeout, "R7", "timeout flag sticky", 64'(err_timeout), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule